// File: doc/BRIEF.md
# Hybrid Analog/PWM LED Brightness Mapper

This block drives the dimming of one LED bank. A 5-bit brightness code is turned into two controls: a 2-bit select that picks one of four analog current steps (20 %, 40 %, 70 % or 100 % of full scale) and a PWM gate whose duty is a whole number of sixteenths. The code table is deliberately non-linear: low codes dim with duty at the smallest current step, higher codes move to larger steps and restart at a reduced duty, so that perceived brightness rises smoothly across the 32 codes. Near the top the table skips a duty value.

A second mode uses only the two low bits of the code to choose the analog step directly and holds the PWM gate continuously on. The PWM period is split into 16 slots; a prescaler derived from the clock and target PWM rate parameters sets the slot length so that the period runs at 20 kHz. The setting in force is captured only at period boundaries, so a code change never cuts a pulse short. Dropping the bank enable darkens the gate at once and parks the slot counter at the start of a period.

Top module: `led_dim_mapper`

## Requirements
- R1: In hybrid mode (steady_mode=0), codes 0 to 15 give level_sel=0 (20 %) and a duty of (code+1) sixteenths.
- R2: In hybrid mode, codes 16 to 22 give level_sel=1 (40 %) and a duty of (code-6) sixteenths, from 10/16 up to 16/16.
- R3: In hybrid mode, codes 23 to 28 give level_sel=2 (70 %) and a duty of (code-12) sixteenths, from 11/16 up to 16/16.
- R4: In hybrid mode, codes 29, 30 and 31 give level_sel=3 (100 %) with duties 13/16, 15/16 and 16/16; a duty of 14/16 never occurs at that level.
- R5: A PWM period is 16 slots of CLK_HZ/(PWM_HZ*16) clock cycles each; pwm_on is high in slots 0 to duty-1 and low for the rest, and a duty of 16/16 keeps it high for the whole period.
- R6: In steady mode (steady_mode=1), bright_code[1:0] values 0,1,2,3 give level_sel 0,1,2,3, bright_code[4:2] has no effect, and pwm_on stays high for as long as the bank is enabled.
- R7: While bank_en is low, pwm_on is low and the slot counter is held at slot 0; when bank_en rises, a new period starts at slot 0 with the code and mode present at that moment.
- R8: A change of bright_code or steady_mode while enabled takes effect on level_sel and pwm_on only at the next period boundary; the period in progress completes with the old setting.
- R9: Under reset, level_sel is 0 and pwm_on is low regardless of bank_en, and the held duty is zero until the first setting is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_en | input | 1 | Bank enable; low darkens the bank and parks the slot counter |
| steady_mode | input | 1 | 0 = hybrid analog/PWM table, 1 = analog step only with PWM held on |
| bright_code | input | 5 | Brightness code |
| level_sel | output | 2 | Analog step: 0=20 %, 1=40 %, 2=70 %, 3=100 % of full scale |
| pwm_on | output | 1 | PWM gate for the bank's current sinks |

## Verification
While the bank is disabled the held setting follows the inputs on every clock, so one clock edge after a code is applied it is in force, and the first enabled sample already shows slot 0 of a fresh period. From there each output sample is compared against a slot index of sample/slot-length, with the period's full 16-slot pattern and the level checked every sample, and a new code applied mid-period is expected only from the first sample after the sixteenth slot. Disabling is checked in the same half-cycle the enable falls, since the gate is combinational on bank_en. The bench shortens the slot to four clocks through the clock-rate parameter so that many periods fit in the run.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

  localparam int CODE_W  = 5;
  localparam int SLOTS   = 16;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int DUTY_W  = SLOT_W + 1;

  typedef enum logic [1:0] {
    LVL_20  = 2'd0,
    LVL_40  = 2'd1,
    LVL_70  = 2'd2,
    LVL_100 = 2'd3
  } level_e;

  typedef struct packed {
    level_e              lvl;
    logic [DUTY_W-1:0]   duty;
    logic                steady;
  } dim_set_t;

  // Hybrid table: each band of codes restarts at a lower duty on a higher step.
  function automatic dim_set_t map_hybrid(input logic [CODE_W-1:0] code);
    dim_set_t s;
    s.steady = 1'b0;
    if (code < 5'd16) begin
      s.lvl  = LVL_20;
      s.duty = DUTY_W'(code) + DUTY_W'(1);
    end else if (code < 5'd23) begin
      s.lvl  = LVL_40;
      s.duty = DUTY_W'(code) - DUTY_W'(6);
    end else if (code < 5'd29) begin
      s.lvl  = LVL_70;
      s.duty = DUTY_W'(code) - DUTY_W'(12);
    end else begin
      s.lvl = LVL_100;
      case (code)
        5'd29:   s.duty = DUTY_W'(13);
        5'd30:   s.duty = DUTY_W'(15);
        default: s.duty = DUTY_W'(16);
      endcase
    end
    return s;
  endfunction

  // Steady table: analog step only, gate held on.
  function automatic dim_set_t map_steady(input logic [1:0] sel);
    dim_set_t s;
    s.steady = 1'b1;
    s.lvl    = level_e'(sel);
    s.duty   = DUTY_W'(SLOTS);
    return s;
  endfunction

  function automatic dim_set_t reset_set();
    dim_set_t s;
    s.steady = 1'b0;
    s.lvl    = LVL_20;
    s.duty   = '0;
    return s;
  endfunction

endpackage

// File: rtl/led_dim_prescaler.sv
module led_dim_prescaler #(
  parameter int DIV = 156
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/led_dim_slot_ctr.sv
module led_dim_slot_ctr
  import led_dim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (!run) begin
      slot_q <= '0;
    end else if (tick) begin
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot = slot_q;
  assign wrap = tick && (slot_q == LAST_SLOT);

endmodule

// File: rtl/led_dim_code_map.sv
module led_dim_code_map
  import led_dim_pkg::*;
(
  input  logic              steady_mode,
  input  logic [CODE_W-1:0] code,
  output dim_set_t          set
);

  dim_set_t hyb;
  dim_set_t std_set;

  always_comb begin
    hyb     = map_hybrid(code);
    std_set = map_steady(code[1:0]);
    set     = steady_mode ? std_set : hyb;
  end

endmodule

// File: rtl/led_dim_hold.sv
module led_dim_hold
  import led_dim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  dim_set_t next_set,
  output dim_set_t held_set
);

  dim_set_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= reset_set();
    end else if (load) begin
      held_q <= next_set;
    end
  end

  assign held_set = held_q;

endmodule

// File: rtl/led_dim_mapper.sv
module led_dim_mapper
  import led_dim_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int PWM_HZ = 20_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_en,
  input  logic                steady_mode,
  input  logic [CODE_W-1:0]   bright_code,
  output logic [1:0]          level_sel,
  output logic                pwm_on
);

  localparam int RAW_DIV  = CLK_HZ / (PWM_HZ * SLOTS);
  localparam int SLOT_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;

  // Named internal events, brought out for the checker.
  logic              slot_tick;
  logic              period_wrap;
  logic              set_load;
  logic [SLOT_W-1:0] slot_q;
  dim_set_t          next_set;
  dim_set_t          held_set;
  logic              slot_lit;

  led_dim_prescaler #(.DIV(SLOT_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (bank_en),
    .tick  (slot_tick)
  );

  led_dim_slot_ctr u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (bank_en),
    .tick  (slot_tick),
    .slot  (slot_q),
    .wrap  (period_wrap)
  );

  led_dim_code_map u_map (
    .steady_mode (steady_mode),
    .code        (bright_code),
    .set         (next_set)
  );

  // Capture a new setting at every period end, and continuously while idle.
  assign set_load = !bank_en || period_wrap;

  led_dim_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (set_load),
    .next_set (next_set),
    .held_set (held_set)
  );

  assign slot_lit  = ({1'b0, slot_q} < held_set.duty);
  assign pwm_on    = bank_en && (held_set.steady || slot_lit);
  assign level_sel = held_set.lvl;

endmodule

// File: rtl/led_dim_mapper_chk.sv
module led_dim_mapper_chk
  import led_dim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bank_en,
  input logic              pwm_on,
  input logic [1:0]        level_sel,
  input logic              load,
  input logic [SLOT_W-1:0] slot,
  input logic              held_steady,
  input logic [DUTY_W-1:0] held_duty
);

  // R7: gate dark whenever the bank is off
  a_r7_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en |-> !pwm_on);

  // R7: slot counter parked at zero after a disabled cycle
  a_r7_slot_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en |=> (slot == '0));

  // R8: level only moves after a capture
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(level_sel));

  // R5: within an enabled run the gate only turns on at a period start
  a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en && $past(bank_en) && $rose(pwm_on)) |-> ($past(load) && slot == '0));

  // R6: steady mode keeps the gate on
  a_r6_steady_on: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en && held_steady) |-> pwm_on);

  // R4: top step in hybrid mode never uses 14/16
  a_r4_top_band: assert property (@(posedge clk) disable iff (!rst_n)
    (level_sel == 2'd3 && !held_steady) |->
      (held_duty == 5'd13 || held_duty == 5'd15 || held_duty == 5'd16));

endmodule

bind led_dim_mapper led_dim_mapper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bank_en     (bank_en),
  .pwm_on      (pwm_on),
  .level_sel   (level_sel),
  .load        (set_load),
  .slot        (slot_q),
  .held_steady (held_set.steady),
  .held_duty   (held_set.duty)
);

// File: tb/led_dim_mapper_tb.sv
module led_dim_mapper_tb;

  localparam int TB_CLK_HZ = 1_280_000;
  localparam int TB_PWM_HZ = 20_000;
  localparam int SLOT_LEN  = TB_CLK_HZ / (TB_PWM_HZ * 16);
  localparam int PER       = 16 * SLOT_LEN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_en = 1'b0;
  logic       steady_mode = 1'b0;
  logic [4:0] bright_code = '0;
  logic [1:0] level_sel;
  logic       pwm_on;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  led_dim_mapper #(.CLK_HZ(TB_CLK_HZ), .PWM_HZ(TB_PWM_HZ)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_en     (bank_en),
    .steady_mode (steady_mode),
    .bright_code (bright_code),
    .level_sel   (level_sel),
    .pwm_on      (pwm_on)
  );

  // Level: band boundaries at 16, 23, 29.
  function automatic int exp_lvl(input logic m, input logic [4:0] c);
    if (m) return int'(c[1:0]);
    if (c >= 5'd29) return 3;
    if (c >= 5'd23) return 2;
    if (c >= 5'd16) return 1;
    return 0;
  endfunction

  // Duty: each lower band ends at 16/16 on its last code; top band is 13,15,16.
  function automatic int exp_duty(input logic m, input logic [4:0] c);
    int band_end;
    if (m) return 16;
    if (c == 5'd29) return 13;
    if (c == 5'd30) return 15;
    if (c == 5'd31) return 16;
    band_end = (c >= 5'd23) ? 28 : (c >= 5'd16) ? 22 : 15;
    return 16 - (band_end - int'(c));
  endfunction

  function automatic string req_of(input logic m, input logic [4:0] c);
    if (m) return "R6";
    if (c >= 5'd29) return "R4";
    if (c >= 5'd23) return "R3";
    if (c >= 5'd16) return "R2";
    return "R1";
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Called at a negedge where sample 0 of a period is visible.
  // Optionally applies new inputs after sample chg_at; returns at the next period's sample 0.
  task automatic run_period(input logic m, input logic [4:0] c, input string req,
                            input int chg_at, input logic nm, input logic [4:0] nc);
    int el, ed, bad_pwm, bad_lvl, fi, fp, fl;
    el = exp_lvl(m, c);
    ed = exp_duty(m, c);
    bad_pwm = 0; bad_lvl = 0; fi = -1; fp = 0; fl = 0;
    for (int i = 0; i < PER; i++) begin
      logic ep;
      ep = ((i / SLOT_LEN) < ed);
      if (pwm_on !== ep) begin
        if (bad_pwm == 0) begin fi = i; fp = int'(pwm_on); end
        bad_pwm++;
      end
      if (int'(level_sel) != el) begin bad_lvl++; fl = int'(level_sel); end
      if (i == chg_at) begin
        steady_mode = nm;
        bright_code = nc;
      end
      @(negedge clk);
      #1;
    end
    checks += 2;
    if (bad_pwm != 0) begin
      failures++;
      $display("FAIL %s/R5 mode=%0b code=%0d pwm at sample %0d: actual=%0d expected=%0d (duty %0d/16)",
               req, m, c, fi, fp, int'(((fi / SLOT_LEN) < ed)), ed);
    end
    if (bad_lvl != 0) begin
      failures++;
      $display("FAIL %s mode=%0b code=%0d level: actual=%0d expected=%0d", req, m, c, fl, el);
    end
  endtask

  task automatic start_fresh(input logic m, input logic [4:0] c);
    bank_en = 1'b0;
    steady_mode = m;
    bright_code = c;
    @(negedge clk);
    bank_en = 1'b1;
    #1;
  endtask

  initial begin
    int seed;
    logic [4:0] dir_codes [9];
    dir_codes = '{5'd0, 5'd15, 5'd16, 5'd22, 5'd23, 5'd28, 5'd29, 5'd30, 5'd31};
    seed = $urandom(32'd20240611);

    // R9: reset state with the bank enabled and a bright code applied
    bank_en = 1'b1;
    bright_code = 5'd31;
    repeat (3) @(negedge clk);
    check_bit("R9 pwm in reset", pwm_on, 1'b0);
    checks++;
    if (level_sel !== 2'd0) begin
      failures++;
      $display("FAIL R9 level in reset: actual=%0d expected=0", level_sel);
    end
    bank_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R7 idle dark", pwm_on, 1'b0);

    // Directed band edges, hybrid mode (R1..R4, R5)
    foreach (dir_codes[k]) begin
      start_fresh(1'b0, dir_codes[k]);
      run_period(1'b0, dir_codes[k], req_of(1'b0, dir_codes[k]), -1, 1'b0, 5'd0);
    end

    // Steady mode with junk in the upper code bits (R6)
    for (int s = 0; s < 4; s++) begin
      logic [4:0] c;
      c = {3'($urandom_range(7, 1)), 2'(s)};
      start_fresh(1'b1, c);
      run_period(1'b1, c, "R6", -1, 1'b1, c);
    end

    // R8: mid-period change applies only from the next period
    start_fresh(1'b0, 5'd3);
    run_period(1'b0, 5'd3, "R8 old", 10, 1'b0, 5'd26);
    run_period(1'b0, 5'd26, "R8 new", 40, 1'b1, 5'd1);
    run_period(1'b1, 5'd1, "R8 mode", -1, 1'b1, 5'd1);

    // R7: disable mid-period, gate dark at once, restart at slot 0 with new code
    start_fresh(1'b0, 5'd31);
    repeat (20) begin @(negedge clk); end
    #1;
    bank_en = 1'b0;
    #1;
    check_bit("R7 dark on disable", pwm_on, 1'b0);
    bright_code = 5'd7;
    repeat (3) begin
      @(negedge clk);
      #1;
      check_bit("R7 dark while off", pwm_on, 1'b0);
    end
    bank_en = 1'b1;
    #1;
    run_period(1'b0, 5'd7, "R7 restart", -1, 1'b0, 5'd7);

    // Random sequences with a mid-period change each
    for (int t = 0; t < 30; t++) begin
      logic m1, m2;
      logic [4:0] c1, c2;
      int at;
      m1 = ($urandom % 4) == 0;
      m2 = ($urandom % 4) == 0;
      c1 = 5'($urandom);
      c2 = 5'($urandom);
      at = int'($urandom % PER);
      start_fresh(m1, c1);
      run_period(m1, c1, req_of(m1, c1), at, m2, c2);
      run_period(m2, c2, "R8", -1, m2, c2);
    end

    bank_en = 1'b0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule